// File: doc/BRIEF.md
# Finite Pulse Train Generator

This block turns a free-running internal rectangular pulse source into a burst of a selectable number of pulses, and then falls silent until it is started again. The source is a programmable divider of the system clock. Its period and its high time are both set in clock cycles, and it never stops. Pulses reach the output only through a gate. After reset the gate is closed. A start strobe clears the pulse counter and arms the gate.

Each pulse that passes the gate moves a five-stage Johnson counter one step along its ten one-hot decoded states. The step happens on the falling edge of the pulse. When the decoded state that matches the latched count select becomes active, the gate closes. The burst therefore ends by itself after exactly the requested number of whole pulses.

The gate opens and closes only while the internal pulse is low, so the output never carries a clipped pulse. A one-cycle done flag marks the end of each burst, and a busy flag covers the burst while it runs.

Top module: `pulse_burst_gen`

## Requirements
- R1: After reset, `pulseOut`, `busy` and `done` are all low, and `pulseOut` stays low for as long as no start strobe arrives.
- R2: A start with a count select N between 1 and 9 yields exactly N pulses on `pulseOut`. The first pulse rises at most P cycles after the start is accepted, where P is the effective period.
- R3: A count select of 0, or of any value above 9, gives a burst of exactly one pulse.
- R4: Every output pulse is whole. It is high for exactly H cycles, and consecutive pulses of a burst are separated by exactly P−H low cycles, where H is the effective high time.
- R5: The effective period P is `periodCfg`, or 2 when `periodCfg` is below 2. The effective high time H is 1 when `highCfg` is 0, is P−1 when `highCfg` is at least P, and is `highCfg` otherwise.
- R6: `done` is high for exactly one cycle, in the cycle that follows the cycle in which the last pulse has fallen. `pulseOut` stays low afterwards until the next start.
- R7: `busy` is high from the cycle after an accepted start until the cycle before `done`. It is low while `done` is high.
- R8: A start strobe received while `busy` is high is ignored. This holds even when it comes with a different count select: the running burst keeps its original length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| startStb | input | 1 | One-cycle request to begin a burst |
| countSel | input | SEL_W | Requested pulse count, 1 to 9 |
| periodCfg | input | PERIOD_W | Source period in clock cycles |
| highCfg | input | PERIOD_W | Source high time in clock cycles |
| pulseOut | output | 1 | Gated pulse output |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst flag |

## Verification
The bench builds the block with its defaults, PERIOD_W = 8 and SEL_W = 4. With an 8-bit divider setting, the bench can test the longest period of 255 cycles alongside the shortest clamped period of 2, and it can test high times that are clamped from both sides. With a 4-bit select, every value from 0 to 15 can be driven, so both out-of-range select cases are exercised next to all nine valid counts. The random bursts mix these settings. Directed bursts cover a restart attempted during a running burst.

// File: rtl/pbg_pkg.sv
`timescale 1ns/1ps
package pbg_pkg;
  localparam int JSTAGES = 5;
  localparam int JSTATES = 2 * JSTAGES;

  typedef struct packed {
    logic clearCnt;
    logic arm;
  } ctrlStrb_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RUN} ctrlState_t;

  // one-hot decode of a twisted-ring state
  function automatic logic [JSTATES-1:0] johnDecode(input logic [JSTAGES-1:0] j);
    logic [JSTATES-1:0] d;
    d[0] = ~j[0] & ~j[JSTAGES-1];
    for (int k = 1; k < JSTAGES; k++) d[k] = j[k-1] & ~j[k];
    d[JSTAGES] = j[0] & j[JSTAGES-1];
    for (int k = JSTAGES + 1; k < JSTATES; k++) d[k] = ~j[k-JSTAGES-1] & j[k-JSTAGES];
    return d;
  endfunction
endpackage

// File: rtl/pbg_datapath.sv
`timescale 1ns/1ps
module pbg_datapath
  import pbg_pkg::*;
#(
  parameter int PERIOD_W = 8,
  parameter int SEL_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrb_t           strb,
  input  logic [SEL_W-1:0]    countSel,
  input  logic [PERIOD_W-1:0] periodCfg,
  input  logic [PERIOD_W-1:0] highCfg,
  output logic                pulseOut,
  output logic                gateOpen,
  output logic                hit
);
  localparam logic [PERIOD_W-1:0] MIN_PERIOD = PERIOD_W'(2);
  localparam logic [PERIOD_W-1:0] ONE_P      = PERIOD_W'(1);
  localparam logic [SEL_W-1:0]    MAX_SEL    = SEL_W'(JSTATES - 1);
  localparam logic [SEL_W-1:0]    ONE_S      = SEL_W'(1);

  logic [PERIOD_W-1:0] effPeriod, effHigh, phaseCnt;
  logic                srcPulse, srcPrev, fall;
  logic [JSTAGES-1:0]  john, nextJohn;
  logic [JSTATES-1:0]  nextDec, selOneHot;
  logic [SEL_W-1:0]    effSel;

  // free-running pulse source
  always_comb begin
    effPeriod = (periodCfg < MIN_PERIOD) ? MIN_PERIOD : periodCfg;
    if (highCfg == '0)              effHigh = ONE_P;
    else if (highCfg >= effPeriod)  effHigh = effPeriod - ONE_P;
    else                            effHigh = highCfg;
  end

  always_ff @(posedge clk) begin
    if (rst)                                phaseCnt <= '0;
    else if (phaseCnt >= effPeriod - ONE_P) phaseCnt <= '0;
    else                                    phaseCnt <= phaseCnt + ONE_P;
  end

  assign srcPulse = (phaseCnt < effHigh);

  always_ff @(posedge clk) begin
    if (rst) srcPrev <= 1'b0;
    else     srcPrev <= srcPulse;
  end

  // falling edge of a pulse that passed the gate
  assign fall = gateOpen & srcPrev & ~srcPulse;

  // count select latch, held as a one-hot target
  assign effSel = (countSel == '0 || countSel > MAX_SEL) ? ONE_S : countSel;

  always_ff @(posedge clk) begin
    if (rst)                selOneHot <= JSTATES'(2);
    else if (strb.clearCnt) selOneHot <= JSTATES'(1) << effSel;
  end

  // twisted-ring pulse counter
  assign nextJohn = {john[JSTAGES-2:0], ~john[JSTAGES-1]};
  assign nextDec  = johnDecode(nextJohn);

  always_ff @(posedge clk) begin
    if (rst || strb.clearCnt) john <= '0;
    else if (fall)            john <= nextJohn;
  end

  assign hit = fall & (|(nextDec & selOneHot));

  // output gate, moved only while the source is low
  always_ff @(posedge clk) begin
    if (rst) gateOpen <= 1'b0;
    else if (!srcPulse) begin
      if (hit)           gateOpen <= 1'b0;
      else if (strb.arm) gateOpen <= 1'b1;
    end
  end

  assign pulseOut = gateOpen & srcPulse;

  // R4
  gate_move_low_chk: assert property (@(posedge clk) disable iff (rst)
    (gateOpen != $past(gateOpen)) |-> !$past(srcPulse));

  // R2
  ring_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(johnDecode(john)) == 1);

  // R2
  close_after_hit_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> !gateOpen);

  // R8
  target_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (gateOpen && !strb.clearCnt) |=> $stable(selOneHot));
endmodule

// File: rtl/pbg_control.sv
`timescale 1ns/1ps
module pbg_control
  import pbg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      startStb,
  input  logic      gateOpen,
  input  logic      hit,
  output ctrlStrb_t strb,
  output logic      busy,
  output logic      done
);
  ctrlState_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (startStb) state <= ST_ARM;
        ST_ARM:  if (gateOpen) state <= ST_RUN;
        ST_RUN:  if (hit) begin
                   state <= ST_IDLE;
                   done  <= 1'b1;
                 end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.clearCnt = (state == ST_IDLE) && startStb;
    strb.arm      = (state == ST_ARM);
  end

  assign busy = (state != ST_IDLE);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8
  restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && startStb && !hit) |=> (state == ST_RUN));

  // R1
  idle_gate_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !gateOpen);
endmodule

// File: rtl/pulse_burst_gen.sv
`timescale 1ns/1ps
module pulse_burst_gen
  import pbg_pkg::*;
#(
  parameter int PERIOD_W = 8,
  parameter int SEL_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                startStb,
  input  logic [SEL_W-1:0]    countSel,
  input  logic [PERIOD_W-1:0] periodCfg,
  input  logic [PERIOD_W-1:0] highCfg,
  output logic                pulseOut,
  output logic                busy,
  output logic                done
);
  ctrlStrb_t strb;
  logic      gateOpen, hit;

  pbg_control i_ctrl (
    .clk(clk), .rst(rst), .startStb(startStb), .gateOpen(gateOpen), .hit(hit),
    .strb(strb), .busy(busy), .done(done)
  );

  pbg_datapath #(.PERIOD_W(PERIOD_W), .SEL_W(SEL_W)) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .countSel(countSel),
    .periodCfg(periodCfg), .highCfg(highCfg),
    .pulseOut(pulseOut), .gateOpen(gateOpen), .hit(hit)
  );
endmodule

// File: tb/test_pulse_burst_gen.sv
`timescale 1ns/1ps
module test_pulse_burst_gen;
  localparam int PW = 8;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          startStb = 1'b0;
  logic [SW-1:0] countSel = '0;
  logic [PW-1:0] periodCfg = '0;
  logic [PW-1:0] highCfg = '0;
  logic          pulseOut, busy, done;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  pulse_burst_gen #(.PERIOD_W(PW), .SEL_W(SW)) i_pulse_burst_gen (
    .clk(clk), .rst(rst), .startStb(startStb), .countSel(countSel),
    .periodCfg(periodCfg), .highCfg(highCfg),
    .pulseOut(pulseOut), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int effP(input int p);
    return (p < 2) ? 2 : p;
  endfunction

  function automatic int effH(input int h, input int p);
    int pp = effP(p);
    if (h == 0) return 1;
    if (h >= pp) return pp - 1;
    return h;
  endfunction

  function automatic int effN(input int s);
    return (s == 0 || s > 9) ? 1 : s;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runBurst(input int sel, input int per, input int hi,
                          input bit extra, input string tag);
    int expP = effP(per);
    int expH = effH(hi, per);
    int expN = effN(sel);
    int limit = 12 * expP + 50;
    int i = 0, hr = 0, lr = 0, rises = 0, lastFall = -1, doneAt = -1, firstRise = -1;
    bit prev = 0, cur, busyOk = 1, quietOk = 1;
    @(negedge clk);
    countSel = SW'(sel); periodCfg = PW'(per); highCfg = PW'(hi); startStb = 1'b1;
    @(negedge clk);
    startStb = 1'b0;
    chk(busy == 1'b1, "R7 busy after start", busy, 1);
    while (doneAt < 0 && i < limit) begin
      cur = pulseOut;
      if (cur && !prev) begin
        if (rises > 0) chk(lr == expP - expH, "R4 low gap", lr, expP - expH);
        else firstRise = i;
        rises++; hr = 1;
      end else if (cur) hr++;
      if (!cur && prev) begin
        chk(hr == expH, "R4 high width", hr, expH);
        lastFall = i; lr = 1;
      end else if (!cur) lr++;
      if (done) begin
        doneAt = i;
        if (busy) busyOk = 0;
      end else if (!busy) busyOk = 0;
      if (extra && i == 3) begin startStb = 1'b1; countSel = SW'(9); end
      if (extra && i == 4) startStb = 1'b0;
      prev = cur; i++;
      @(negedge clk);
    end
    chk(doneAt >= 0, "R6 done seen", doneAt, 0);
    chk(rises == expN, tag, rises, expN);
    chk(doneAt == lastFall + 1, "R6 done one cycle after last fall", doneAt, lastFall + 1);
    chk(busyOk, "R7 busy window", busyOk, 1);
    chk(firstRise >= 0 && firstRise <= expP, "R2 first pulse latency", firstRise, expP);
    chk(done == 1'b0, "R6 done lasts one cycle", done, 0);
    for (int k = 0; k < 2 * expP + 3; k++) begin
      if (pulseOut || busy) quietOk = 0;
      @(negedge clk);
    end
    chk(quietOk, "R6 quiet after done", quietOk, 1);
  endtask

  initial begin
    bit r1Ok = 1;
    void'($urandom(32'h5eed1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    chk(pulseOut == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 reset outputs", {pulseOut, busy, done}, 0);
    periodCfg = PW'(3); highCfg = PW'(1);
    for (int k = 0; k < 30; k++) begin
      if (pulseOut || busy || done) r1Ok = 0;
      @(negedge clk);
    end
    chk(r1Ok, "R1 silent without start", r1Ok, 1);

    for (int s = 1; s <= 9; s++) runBurst(s, 4, 2, 1'b0, "R2 pulse count");
    runBurst(0, 5, 2, 1'b0, "R3 select zero");
    runBurst(12, 5, 3, 1'b0, "R3 select above nine");
    runBurst(15, 3, 1, 1'b0, "R3 select fifteen");
    runBurst(3, 0, 0, 1'b0, "R5 clamped period and high");
    runBurst(4, 5, 9, 1'b0, "R5 high clamped to period-1");
    runBurst(2, 255, 1, 1'b0, "R5 longest period");
    runBurst(5, 2, 1, 1'b0, "R4 shortest period");
    runBurst(6, 7, 6, 1'b0, "R4 high one below period");
    runBurst(5, 6, 3, 1'b1, "R8 restart while busy ignored");
    runBurst(2, 9, 4, 1'b1, "R8 restart ignored short count");

    for (int r = 0; r < 20; r++) begin
      int s = int'($urandom % 16);
      int p = int'($urandom % 25);
      int h = int'($urandom % 25);
      runBurst(s, p, h, 1'b0, "R2 random burst count");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule